// File: doc/BRIEF.md
# Dual-Clock 32-to-64 Width-Doubling FIFO

This block moves a stream of 32-bit words from one clock domain into another and hands it over as 64-bit words. Two 32-bit words written in turn on the write clock make up one 64-bit word, which the read side pulls out on its own unrelated clock. The first word written lands in the low half and the second in the high half. A single unpaired 32-bit word is never shown to the reader.

The write side is a valid/ready stream. A word is taken on a write-clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls when all 32 narrow slots are occupied, and a producer must hold its word until it sees ready. The read side is request/empty. A request on a read-clock edge while `out_empty` is low takes the oldest 64-bit word. That word sits in an output register from the following edge on and stays there until the next accepted request.

Each pointer moves into the other domain in Gray code through a two-stage synchronizer. The write pointer counts narrow words and the read pointer counts wide words, and each carries one wrap bit. The write count divided by two is what the read side compares against its own count. An asynchronous reset clears both pointers, the synchronizers and the output register.

Top module: `widen_async_fifo`

## Requirements
- R1: While reset is high and after it is released, `out_empty` is 1, `in_ready` is 1 and `out_data` is zero.
- R2: The 64-bit word read back carries the earlier-written 32-bit word in bits [31:0] and the later-written one in bits [63:32]. For example, writing 0x00000000 then 0x00000001 reads back 0x0000000100000000.
- R3: With an odd number of narrow words written and all whole pairs read out, `out_empty` stays 1. It falls only once the second word of the pair is written.
- R4: From empty, exactly 32 narrow words are accepted before `in_ready` goes low. It stays low until a wide word is read.
- R5: A write offered while `in_ready` is low is dropped. It changes neither the stored words nor the write pointer.
- R6: A request made while `out_empty` is 1 is ignored. `out_data` and the read pointer are unchanged.
- R7: `out_data` changes only on the read-clock edge that accepts a request. It then shows the accepted word and holds it through any cycles with no accepted request.
- R8: Words come out in write order, and this holds across the wrap of both pointers.
- R9: Asserting reset in the middle of traffic discards all stored words. Traffic after release starts again from an empty FIFO with correct pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, unrelated to wr_clk |
| rst | input | 1 | Asynchronous reset, active high, both domains |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | FIFO can take a narrow word (not full) |
| in_data | input | 32 | Narrow word to store |
| out_req | input | 1 | Reader requests the oldest wide word |
| out_empty | output | 1 | No complete wide word is available |
| out_data | output | 64 | Registered wide word from the last accepted request |

## Verification
A table of eight word pairs with different patterns is streamed through one pair at a time: all zeros, all ones, walking bits and values whose halves differ only in their top or bottom bits. This shows whether the halves are packed in the right order or swapped, and whether the first word is lost or the pairing slips by one. A fill to capacity followed by a full drain shows the exact full threshold, and it shows that a dropped write on a full FIFO leaves no trace. Because the table runs after the pointers have already wrapped, it also covers ordering across the wrap. Further directed tests cover a lone word, reads on an empty FIFO, output hold between reads, and reset during traffic.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int unsigned CONV_W = 16;

  function automatic logic [CONV_W-1:0] bin_to_gray(input logic [CONV_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CONV_W-1:0] gray_to_bin(input logic [CONV_W-1:0] g);
    logic [CONV_W-1:0] b;
    b[CONV_W-1] = g[CONV_W-1];
    for (int i = CONV_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/wf_sync.sv
module wf_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/wf_wr_side.sv
module wf_wr_side #(
  parameter int unsigned WIDE_AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDE_AW:0] rgray_sync,
  output logic [WIDE_AW+1:0] wptr,
  output logic [WIDE_AW+1:0] wgray,
  output logic             wen
);
  import wf_pkg::*;
  localparam int unsigned PW  = WIDE_AW + 2;
  localparam int unsigned RPW = WIDE_AW + 1;
  localparam logic [PW-1:0] CAP = PW'(2 * (1 << WIDE_AW));

  logic [RPW-1:0] rbin;
  logic [PW-1:0]  fill;
  logic [PW-1:0]  wptr_nxt;
  logic           full;

  always_comb begin
    rbin     = RPW'(gray_to_bin(CONV_W'(rgray_sync)));
    fill     = wptr - {rbin, 1'b0};
    full     = (fill == CAP);
    wen      = in_valid && !full;
    wptr_nxt = wptr + PW'(wen);
  end

  assign in_ready = !full;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= wptr_nxt;
      wgray <= PW'(bin_to_gray(CONV_W'(wptr_nxt)));
    end
  end

  p_drop_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> $stable(wptr));
  p_fill_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    fill <= CAP);
  p_wgray_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/wf_rd_side.sv
module wf_rd_side #(
  parameter int unsigned WIDE_AW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               out_req,
  output logic               out_empty,
  input  logic [WIDE_AW+1:0] wgray_sync,
  output logic [WIDE_AW:0]   rptr,
  output logic [WIDE_AW:0]   rgray,
  output logic               ren
);
  import wf_pkg::*;
  localparam int unsigned PW  = WIDE_AW + 2;
  localparam int unsigned RPW = WIDE_AW + 1;

  logic [PW-1:0]  wbin;
  logic [RPW-1:0] rptr_nxt;

  always_comb begin
    wbin      = PW'(gray_to_bin(CONV_W'(wgray_sync)));
    out_empty = (wbin[PW-1:1] == rptr);
    ren       = out_req && !out_empty;
    rptr_nxt  = rptr + RPW'(ren);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rptr  <= '0;
      rgray <= '0;
    end else begin
      rptr  <= rptr_nxt;
      rgray <= RPW'(bin_to_gray(CONV_W'(rptr_nxt)));
    end
  end

  p_no_read_when_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (out_req && out_empty) |=> $stable(rptr));
  p_rgray_step_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/wf_store.sv
module wf_store #(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_AW  = 4
) (
  input  logic                  wr_clk,
  input  logic                  wen,
  input  logic [WIDE_AW:0]      waddr,
  input  logic [NARROW_W-1:0]   wdata,
  input  logic                  rd_clk,
  input  logic                  rst,
  input  logic                  ren,
  input  logic [WIDE_AW-1:0]    raddr,
  output logic [2*NARROW_W-1:0] rdata
);
  localparam int unsigned ROWS  = 1 << WIDE_AW;
  localparam int unsigned LANES = 2;

  logic [NARROW_W-1:0] lane_q [LANES];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [NARROW_W-1:0] mem [ROWS];
    always_ff @(posedge wr_clk) begin
      if (wen && (waddr[0] == 1'(ln))) mem[waddr[WIDE_AW:1]] <= wdata;
    end
    assign lane_q[ln] = mem[raddr];
  end

  always_ff @(posedge rd_clk or posedge rst) begin
    if (rst)      rdata <= '0;
    else if (ren) rdata <= {lane_q[1], lane_q[0]};
  end

  p_out_hold_r7: assert property (@(posedge rd_clk) disable iff (rst)
    !ren |=> $stable(rdata));
endmodule

// File: rtl/widen_async_fifo.sv
module widen_async_fifo #(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_AW  = 4
) (
  input  logic                  wr_clk,
  input  logic                  rd_clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NARROW_W-1:0]   in_data,
  input  logic                  out_req,
  output logic                  out_empty,
  output logic [2*NARROW_W-1:0] out_data
);
  localparam int unsigned PW  = WIDE_AW + 2;
  localparam int unsigned RPW = WIDE_AW + 1;

  logic [PW-1:0]  wptr, wgray, wgray_rd;
  logic [RPW-1:0] rptr, rgray, rgray_wr;
  logic           wen, ren;

  wf_wr_side #(.WIDE_AW(WIDE_AW)) u_wr (
    .clk(wr_clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .rgray_sync(rgray_wr), .wptr(wptr), .wgray(wgray), .wen(wen)
  );

  wf_rd_side #(.WIDE_AW(WIDE_AW)) u_rd (
    .clk(rd_clk), .rst(rst), .out_req(out_req), .out_empty(out_empty),
    .wgray_sync(wgray_rd), .rptr(rptr), .rgray(rgray), .ren(ren)
  );

  wf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_rd));
  wf_sync #(.W(RPW)) u_r2w (.clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_wr));

  wf_store #(.NARROW_W(NARROW_W), .WIDE_AW(WIDE_AW)) u_mem (
    .wr_clk(wr_clk), .wen(wen), .waddr(wptr[PW-2:0]), .wdata(in_data),
    .rd_clk(rd_clk), .rst(rst), .ren(ren), .raddr(rptr[RPW-2:0]),
    .rdata(out_data)
  );
endmodule

// File: tb/widen_async_fifo_bench.sv
module widen_async_fifo_bench;
  logic        wr_clk = 0, rd_clk = 0, rst = 1;
  logic        in_valid = 0, out_req = 0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_empty;
  logic [63:0] out_data;
  int vectors = 0, miscompares = 0;

  always #4 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  widen_async_fifo u_widen_async_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_req(out_req),
    .out_empty(out_empty), .out_data(out_data)
  );

  localparam logic [31:0] TBL [0:15] = '{
    32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000,
    32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 32'h8000_0000,
    32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h1234_5678, 32'h9ABC_DEF0,
    32'hFFFF_FFFE, 32'h7FFF_FFFF, 32'h0F0F_0F0F, 32'hF0F0_F0F0};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge wr_clk); in_valid = 1; in_data = v;
    @(negedge wr_clk); in_valid = 0;
  endtask

  task automatic pop(output logic [63:0] d);
    int n = 0;
    @(negedge rd_clk);
    while (out_empty && n < 60) begin @(negedge rd_clk); n++; end
    check("R3 data available", out_empty, 0);
    out_req = 1;
    @(negedge rd_clk); out_req = 0;
    d = out_data;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  initial begin
    #1_000_000;
    vectors++; miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] d, held;
    #3;
    check("R1 empty in reset", out_empty, 1);
    check("R1 ready in reset", in_ready, 1);
    repeat (3) @(negedge wr_clk);
    rst = 0;
    settle();
    check("R1 empty after reset", out_empty, 1);
    check("R1 ready after reset", in_ready, 1);
    check("R1 data after reset", out_data, 0);

    // R3 lone word stays hidden
    push(32'h1111_0000);
    settle();
    check("R3 lone word keeps empty", out_empty, 1);
    push(32'h2222_0001);
    settle();
    check("R3 pair clears empty", out_empty, 0);
    pop(d);
    check("R2 packing order", d, 64'h2222_0001_1111_0000);

    // R7 hold while no request
    held = d;
    repeat (6) @(negedge rd_clk);
    check("R7 output holds", out_data, held);

    // R6 request on empty ignored
    out_req = 1;
    repeat (3) @(negedge rd_clk);
    out_req = 0;
    check("R6 data unchanged on empty read", out_data, held);
    check("R6 still empty", out_empty, 1);
    push(32'h0000_000A); push(32'h0000_000B);
    pop(d);
    check("R6 pointer not advanced", d, 64'h0000_000B_0000_000A);

    // R4 capacity and R5 dropped write
    for (int i = 0; i < 31; i++) begin
      push(32'h100 + i);
      check("R4 ready before capacity", in_ready, 1);
    end
    push(32'h100 + 31);
    check("R4 ready low at 32 words", in_ready, 0);
    @(negedge wr_clk); in_valid = 1; in_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge wr_clk); in_valid = 0;
    check("R5 still full", in_ready, 0);
    for (int i = 0; i < 16; i++) begin
      pop(d);
      check("R5 R8 drained word", d, {32'(32'h100 + 2*i + 1), 32'(32'h100 + 2*i)});
      if (i == 0) begin
        repeat (4) @(negedge wr_clk);
        check("R4 ready after one read", in_ready, 1);
      end
    end
    settle();
    check("R5 dropped word not stored", out_empty, 1);

    // R8 table across pointer wrap, R2 packing
    for (int i = 0; i < 8; i++) begin
      push(TBL[2*i]); push(TBL[2*i+1]);
      pop(d);
      check("R2 R8 table pair", d, {TBL[2*i+1], TBL[2*i]});
    end

    // R9 reset mid-traffic
    push(32'h3333_3333); push(32'h4444_4444); push(32'h5555_5555);
    settle();
    @(negedge wr_clk); rst = 1; #1;
    check("R9 empty on reset", out_empty, 1);
    check("R9 ready on reset", in_ready, 1);
    check("R9 data cleared", out_data, 0);
    @(negedge wr_clk); rst = 0;
    settle();
    check("R9 empty after release", out_empty, 1);
    push(32'h0000_000C); push(32'h0000_000D);
    pop(d);
    check("R9 fresh pairing", d, 64'h0000_000D_0000_000C);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule